// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its contents alive. After reset it stays silent for a programmable pause. It then runs a fixed number of start-up refresh cycles. After that it raises a refresh request every programmable interval. The access controller is kept blocked until `init_done` goes high.

A refresh cycle needs the memory strobes. The sequencer raises `ref_req`, and the access controller answers with `ref_gnt` once its own cycle has ended. While it holds the grant, the sequencer drives the row strobe and both byte column strobes, and it flags `strobe_own` so that the controller can switch the strobe multiplexers and keep the data bus released.

In the default mode each cycle drops both column strobes first and the row strobe second, so the device uses its own row counter. A parameter selects an alternative mode that keeps the column strobes high. In that mode the block presents a 9-bit row address taken from its own counter.

If the grant is late, interval expiries are counted up to `PEND_MAX`. They are then served back to back once the grant arrives.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `cas_lo_n` and `cas_hi_n` are 1, and `ref_req`, `init_done`, `strobe_own` and `addr_en` are 0.
- R2: After reset is released, `ref_req` stays 0 for exactly `PAUSE_CYCLES` clocks and rises on the clock edge that ends the pause.
- R3: Exactly `INIT_CYCLES` refresh cycles run after the pause. `init_done` rises on the edge that completes the last of them and stays 1 until reset. `ref_req` is 0 at that moment.
- R4: In default mode, a cycle holds both column strobes low for `CSR_CYC` clocks with the row strobe high. It then holds the row strobe low for `RAS_CYC` clocks, with the column strobes still low for the first `CHR_CYC` of those clocks. Afterwards all strobes are high for at least `RP_CYC` clocks before the next cycle starts.
- R5: A cycle starts only on an edge where `ref_gnt` is 1. The strobes change only while `strobe_own` is 1 and `ref_gnt` is 1. With no grant, `ref_req` stays high and the strobes stay high.
- R6: Once `init_done` is 1, a request is raised every `max(interval,1)` clocks. With a constant grant, consecutive rising edges of `ref_req` are `interval` clocks apart, provided that `interval` exceeds the cycle length plus one.
- R7: Interval expiries that occur without a grant are kept up to `PEND_MAX`. When the grant arrives, exactly that many cycles run before `ref_req` falls.
- R8: `ref_req` stays 1 for as long as `strobe_own` is 1. It never falls in the middle of a cycle.
- R9: In row-address mode (`RAS_ONLY`=1), both column strobes stay 1 throughout. `addr_en` is 1 and `row_addr` holds the current row whenever the row strobe is low. The row starts at 0 after reset, advances by one when each cycle ends, and wraps from 511 to 0.
- R10: `cas_lo_n` and `cas_hi_n` always carry the same value, so that every row in both byte halves is refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts the power-up pause |
| interval | input | IVL_W | Refresh period in clocks (0 behaves as 1) |
| ref_gnt | input | 1 | Grant from the access controller; held while `ref_req` is high |
| ref_req | output | 1 | Request for the strobes |
| init_done | output | 1 | Start-up sequence complete; normal access allowed |
| strobe_own | output | 1 | Sequencer is driving the strobes this clock |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| addr_en | output | 1 | Row-address mode: sequencer drives the address bus |
| row_addr | output | ROW_W | Row address for row-address mode (0 otherwise) |

## Verification
The bench runs two small configurations side by side. One uses the default column-first mode. The other uses row-address mode, in which more than 512 cycles are run so that every row value and the wrap back to zero are compared with an arithmetic expected row.

For the default mode, the grant is first withheld through the pause and then held. This separates the pause length from the start-up cycle count. The interval is then changed between two values, which shows that the period follows the input rather than a fixed constant. A long withheld grant across several expiries tells a saturating pending count apart from one that drops or overcounts requests.

Every strobe edge is timed against the cycle parameters.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  // Phase of the start-up sequence.
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // Steps inside one refresh cycle.
  typedef enum logic [1:0] {
    CY_IDLE = 2'd0,
    CY_LEAD = 2'd1,  // column strobes low (or address setup), row strobe high
    CY_ACT  = 2'd2,  // row strobe low
    CY_PRE  = 2'd3   // all strobes high, precharge
  } cyc_state_e;

endpackage

// File: rtl/dram_ref_phase.sv
module dram_ref_phase
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYCLES = 12500,
  parameter int INIT_CYCLES  = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_done,
  output phase_e phase,
  output logic   init_need
);

  localparam int PW = $clog2(PAUSE_CYCLES + 1);
  localparam int NW = $clog2(INIT_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYCLES - 1);
  localparam logic [NW-1:0] INIT_N     = NW'(INIT_CYCLES);

  logic [PW-1:0] pause_cnt;
  logic [NW-1:0] init_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pause_cnt <= '0;
      init_left <= INIT_N;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (pause_cnt == PAUSE_LAST) phase <= PH_INIT;
          else pause_cnt <= pause_cnt + PW'(1);
        end
        PH_INIT: begin
          if (cyc_done) begin
            if (init_left == NW'(1)) phase <= PH_RUN;
            init_left <= init_left - NW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign init_need = (phase == PH_INIT);

endmodule

// File: rtl/dram_ref_pacer.sv
module dram_ref_pacer #(
  parameter int IVL_W    = 16,
  parameter int PEND_MAX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IVL_W-1:0] interval,
  input  logic             cyc_done,
  output logic             pend_nz
);

  localparam int PDW = $clog2(PEND_MAX + 1);
  localparam logic [PDW-1:0] PEND_TOP = PDW'(PEND_MAX);

  logic [IVL_W-1:0] cnt;
  logic [PDW-1:0]   pend;
  logic [IVL_W:0]   cnt_next;
  logic             tick;
  logic             take;

  assign cnt_next = {1'b0, cnt} + (IVL_W+1)'(1);
  assign tick     = run && (cnt_next >= {1'b0, interval});
  assign take     = run && cyc_done && (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt_next[IVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (pend != PEND_TOP) pend <= pend + PDW'(1);
        2'b01:   pend <= pend - PDW'(1);
        default: ;
      endcase
    end
  end

  assign pend_nz = (pend != '0);

endmodule

// File: rtl/dram_ref_cycle.sv
module dram_ref_cycle
  import dram_ref_pkg::*;
#(
  parameter int CSR_CYC  = 1,
  parameter int RAS_CYC  = 4,
  parameter int CHR_CYC  = 1,
  parameter int RP_CYC   = 3,
  parameter bit RAS_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic addr_en
);

  localparam int MAXC = (CSR_CYC > RAS_CYC) ?
                        ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC) :
                        ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] ACT_LAST  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] HOLD_N    = CW'(CHR_CYC);

  cyc_state_e state;
  logic [CW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CY_IDLE;
      tcnt  <= '0;
    end else begin
      case (state)
        CY_IDLE: begin
          tcnt <= '0;
          if (start) state <= CY_LEAD;
        end
        CY_LEAD: begin
          if (tcnt == LEAD_LAST) begin
            state <= CY_ACT;
            tcnt  <= '0;
          end else tcnt <= tcnt + CW'(1);
        end
        CY_ACT: begin
          if (tcnt == ACT_LAST) begin
            state <= CY_PRE;
            tcnt  <= '0;
          end else tcnt <= tcnt + CW'(1);
        end
        default: begin
          if (tcnt == PRE_LAST) begin
            state <= CY_IDLE;
            tcnt  <= '0;
          end else tcnt <= tcnt + CW'(1);
        end
      endcase
    end
  end

  assign busy  = (state != CY_IDLE);
  assign done  = (state == CY_PRE) && (tcnt == PRE_LAST);
  assign ras_n = (state != CY_ACT);

  generate
    if (RAS_ONLY) begin : g_row_mode
      assign cas_n   = 1'b1;
      assign addr_en = (state == CY_LEAD) || (state == CY_ACT);
    end else begin : g_cbr_mode
      assign cas_n   = !((state == CY_LEAD) ||
                         ((state == CY_ACT) && (tcnt < HOLD_N)));
      assign addr_en = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dram_ref_rowctr.sv
module dram_ref_rowctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + ROW_W'(1);
  end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYCLES = 12500,
  parameter int INIT_CYCLES  = 8,
  parameter int IVL_W        = 16,
  parameter int PEND_MAX     = 4,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 4,
  parameter int CHR_CYC      = 1,
  parameter int RP_CYC       = 3,
  parameter int ROW_W        = 9,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] interval,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             init_done,
  output logic             strobe_own,
  output logic             ras_n,
  output logic             cas_lo_n,
  output logic             cas_hi_n,
  output logic             addr_en,
  output logic [ROW_W-1:0] row_addr
);

  phase_e phase;
  logic   init_need;
  logic   pend_nz;
  logic   busy;
  logic   done;
  logic   cas_n;
  logic   need;
  logic   start;
  logic   running;

  assign running = (phase == PH_RUN);
  assign need    = init_need || (running && pend_nz);
  assign start   = !busy && need && ref_gnt;

  dram_ref_phase #(
    .PAUSE_CYCLES (PAUSE_CYCLES),
    .INIT_CYCLES  (INIT_CYCLES)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_done  (done),
    .phase     (phase),
    .init_need (init_need)
  );

  dram_ref_pacer #(
    .IVL_W    (IVL_W),
    .PEND_MAX (PEND_MAX)
  ) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .interval (interval),
    .cyc_done (done),
    .pend_nz  (pend_nz)
  );

  dram_ref_cycle #(
    .CSR_CYC  (CSR_CYC),
    .RAS_CYC  (RAS_CYC),
    .CHR_CYC  (CHR_CYC),
    .RP_CYC   (RP_CYC),
    .RAS_ONLY (RAS_ONLY)
  ) u_cycle (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .addr_en (addr_en)
  );

  generate
    if (RAS_ONLY) begin : g_rows
      dram_ref_rowctr #(.ROW_W(ROW_W)) u_rowctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (done),
        .row   (row_addr)
      );
    end else begin : g_norows
      assign row_addr = '0;
    end
  endgenerate

  assign cas_lo_n   = cas_n;
  assign cas_hi_n   = cas_n;
  assign strobe_own = busy;
  assign ref_req    = need || busy;
  assign init_done  = running;

endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int PAUSE_CYCLES = 12500,
  parameter int IVL_W        = 16,
  parameter int ROW_W        = 9,
  parameter bit RAS_ONLY     = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IVL_W-1:0] interval,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             init_done,
  input logic             strobe_own,
  input logic             ras_n,
  input logic             cas_lo_n,
  input logic             cas_hi_n,
  input logic             addr_en,
  input logic [ROW_W-1:0] row_addr
);

  localparam int SW = $clog2(PAUSE_CYCLES + 1);
  localparam logic [SW-1:0] PAUSE_N = SW'(PAUSE_CYCLES);

  logic [SW-1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)                since <= '0;
    else if (since != PAUSE_N) since <= since + SW'(1);
  end

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since < PAUSE_N) |-> !ref_req);

  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!RAS_ONLY && $fell(ras_n)) |-> (!cas_lo_n && $past(!cas_lo_n)));

  assert_own_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_own |-> ref_gnt);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_own |-> (ras_n && cas_lo_n && cas_hi_n));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_own |-> ref_req);

  assert_row_cas_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    RAS_ONLY |-> (cas_lo_n && cas_hi_n));

  assert_row_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY && !ras_n) |-> addr_en);

  assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (RAS_ONLY && $fell(strobe_own)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

  assert_byte_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_lo_n) |-> $fell(cas_hi_n));

endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .PAUSE_CYCLES (PAUSE_CYCLES),
  .IVL_W        (IVL_W),
  .ROW_W        (ROW_W),
  .RAS_ONLY     (RAS_ONLY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .interval   (interval),
  .ref_gnt    (ref_gnt),
  .ref_req    (ref_req),
  .init_done  (init_done),
  .strobe_own (strobe_own),
  .ras_n      (ras_n),
  .cas_lo_n   (cas_lo_n),
  .cas_hi_n   (cas_hi_n),
  .addr_en    (addr_en),
  .row_addr   (row_addr)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

  localparam int PAUSE1 = 20;
  localparam int PAUSE2 = 5;
  localparam int INIT_N = 8;
  localparam int CSR    = 2;
  localparam int RASW   = 4;
  localparam int CHR    = 2;
  localparam int RP     = 3;
  localparam int PMAX   = 3;
  localparam int IW     = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [IW-1:0] ivl1, ivl2;
  logic          gnt1, gnt2;
  logic          req1, done1, own1, ras1, cl1, ch1, ae1;
  logic          req2, done2, own2, ras2, cl2, ch2, ae2;
  logic [8:0]    row1, row2;

  dram_refresh_seq #(
    .PAUSE_CYCLES(PAUSE1), .INIT_CYCLES(INIT_N), .IVL_W(IW), .PEND_MAX(PMAX),
    .CSR_CYC(CSR), .RAS_CYC(RASW), .CHR_CYC(CHR), .RP_CYC(RP), .ROW_W(9), .RAS_ONLY(1'b0)
  ) i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .interval(ivl1), .ref_gnt(gnt1), .ref_req(req1),
    .init_done(done1), .strobe_own(own1), .ras_n(ras1), .cas_lo_n(cl1),
    .cas_hi_n(ch1), .addr_en(ae1), .row_addr(row1)
  );

  dram_refresh_seq #(
    .PAUSE_CYCLES(PAUSE2), .INIT_CYCLES(INIT_N), .IVL_W(IW), .PEND_MAX(PMAX),
    .CSR_CYC(CSR), .RAS_CYC(RASW), .CHR_CYC(CHR), .RP_CYC(RP), .ROW_W(9), .RAS_ONLY(1'b1)
  ) i_dram_refresh_seq_rows (
    .clk(clk), .rst_n(rst_n), .interval(ivl2), .ref_gnt(gnt2), .ref_req(req2),
    .init_done(done2), .strobe_own(own2), .ras_n(ras2), .cas_lo_n(cl2),
    .cas_hi_n(ch2), .addr_en(ae2), .row_addr(row2)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 1'b0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Edge timing monitor for the column-first instance.
  int  cyc1 = 0, lead_run = 0, hold_run = 0, low_run = 0, pre_run = 0;
  logic p_ras1 = 1'b1, p_cas1 = 1'b1, p_req1 = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc1 = 0; lead_run = 0; hold_run = 0; low_run = 0; pre_run = 0;
      p_ras1 = 1'b1; p_cas1 = 1'b1; p_req1 = 1'b0;
    end else begin
      if (ras1 !== p_ras1 || cl1 !== p_cas1)
        chk(own1 && gnt1, "R5 strobe change with own and grant", {own1, gnt1}, 3);
      if (cl1 !== p_cas1)
        chk(cl1 === ch1, "R10 byte strobes equal", ch1, cl1);
      if (p_req1 && !req1)
        chk(!own1, "R8 request fell during cycle", own1, 0);
      if (ras1 && !cl1) begin
        if (p_cas1) begin
          if (cyc1 > 0) chk(pre_run >= RP, "R4 precharge length", pre_run, RP);
          lead_run = 1;
        end else lead_run++;
      end
      if (!ras1 && p_ras1) begin
        chk(lead_run == CSR, "R4 column lead before row strobe", lead_run, CSR);
        low_run  = 1;
        hold_run = cl1 ? 0 : 1;
      end else if (!ras1) begin
        low_run++;
        if (!cl1) hold_run++;
      end
      if (ras1 && !p_ras1) begin
        chk(low_run == RASW, "R4 row strobe width", low_run, RASW);
        chk(hold_run == CHR, "R4 column hold after row fall", hold_run, CHR);
        cyc1++;
        pre_run = 1;
      end else if (ras1 && cl1) pre_run++;
      p_ras1 = ras1; p_cas1 = cl1; p_req1 = req1;
    end
  end

  // Row monitor for the row-address instance.
  int cyc2 = 0, exp_row = 0;
  bit wrap_seen = 1'b0;
  logic p_ras2 = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc2 = 0; exp_row = 0; p_ras2 = 1'b1;
    end else begin
      if (!ras2 && p_ras2) begin
        chk(ae2 === 1'b1, "R9 address driven during row strobe", ae2, 1);
        chk(int'(row2) == exp_row, "R9 row address value", row2, exp_row);
        chk(cl2 && ch2, "R9 column strobes high", {cl2, ch2}, 3);
        if (cyc2 == 512) wrap_seen = (row2 == 9'd0);
      end
      if (ras2 && !p_ras2) begin
        cyc2++;
        exp_row = (exp_row + 1) % 512;
      end
      p_ras2 = ras2;
    end
  end

  task automatic wait_rise(output longint t);
    logic last;
    last = req1;
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (req1 && !last) begin
        t = cyc;
        return;
      end
      last = req1;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=running expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int n, c0;
    longint t0, t1, t2, t3;
    rst_n = 1'b0; gnt1 = 1'b0; gnt2 = 1'b1; ivl1 = 8'd30; ivl2 = 8'd12;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras1 && cl1 && ch1, "R1 strobes high in reset", {ras1, cl1, ch1}, 7);
    chk(!req1 && !done1 && !own1 && !ae1, "R1 outputs low in reset", {req1, done1, own1, ae1}, 0);
    chk(ras2 && cl2 && ch2 && !req2 && !ae2, "R1 row instance idle in reset", {ras2, cl2, ch2, req2, ae2}, 28);

    rst_n = 1'b1;
    n = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      if (req1) break;
    end
    chk(n == PAUSE1, "R2 pause length", n, PAUSE1);

    c0 = cyc1;
    repeat (20) @(negedge clk);
    chk(req1 && ras1 && (cyc1 == c0), "R5 no cycle without grant", cyc1 - c0, 0);

    gnt1 = 1'b1;
    n = 0;
    while (!done1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(cyc1 == INIT_N, "R3 start-up cycle count", cyc1, INIT_N);
    chk(done1 && !req1, "R3 init_done high, request idle", {done1, req1}, 2);

    wait_rise(t0);
    wait_rise(t1);
    chk(t1 - t0 == 30, "R6 period at interval 30", t1 - t0, 30);
    ivl1 = 8'd45;
    wait_rise(t2);
    chk(t2 - t1 == 45, "R6 period at interval 45", t2 - t1, 45);
    wait_rise(t3);
    chk(t3 - t2 == 45, "R6 period repeat at interval 45", t3 - t2, 45);

    wait_rise(t0);
    gnt1 = 1'b0;
    ivl1 = 8'd200;
    c0 = cyc1;
    repeat (650) @(negedge clk);
    chk(cyc1 == c0 && ras1, "R5 strobes idle while grant withheld", cyc1 - c0, 0);
    chk(req1, "R7 request held while pending", req1, 1);
    gnt1 = 1'b1;
    n = 0;
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (!req1) break;
    end
    chk(cyc1 - c0 == PMAX, "R7 saturated backlog served", cyc1 - c0, PMAX);
    chk(done1, "R3 init_done stays high", done1, 1);

    n = 0;
    while (cyc2 < 520 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(cyc2 >= 520, "R9 row instance cycle count", cyc2, 520);
    chk(wrap_seen, "R9 row wraps 511 to 0", wrap_seen, 1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule